// File: doc/BRIEF.md
# Two-Byte I2C Configuration Receiver

This block is a receive-only slave on a two-wire I2C bus whose only job is to load a 16-bit configuration word. A bus master opens a transfer with a START condition, sends a 7-bit address and a write bit, then sends two data bytes. The first byte fills the upper half of the word and the second fills the lower half. The slave acknowledges each byte it accepts by pulling the data line low. It never drives the line high. Instead, the `sda_pull_low` output drives an external open-drain stage.

Both bus lines are brought into the system clock domain through synchroniser flops and then edge-detected. The system clock must run at least eight times faster than the bus bit rate. The upper six address bits are a parameter. The lowest address bit is the inverse of the `addr_pick` pin, so two of these receivers can share a bus. Reads, clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_word_rx`

## Requirements
- R1: After reset, `cfg_word` is 16'h0000 and `sda_pull_low` is 0 (line released).
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The line stays released between a STOP and the next START.
- R3: The address byte is accepted when its first seven bits, sent MSB first, equal 0010111 with `addr_pick` low or 0010110 with `addr_pick` high, and its eighth bit (write bit) is 0.
- R4: An address byte carrying any other address gets no acknowledge. The data bytes that follow are neither acknowledged nor stored until the next START.
- R5: An address byte with the eighth bit equal to 1 (read) gets no acknowledge, and the bytes that follow leave `cfg_word` unchanged.
- R6: For every accepted byte, `sda_pull_low` is 1 throughout the SCL high time of the ninth clock pulse. It goes to 1 and back to 0 only while SCL is low.
- R7: The first data byte after an accepted address is written to `cfg_word[15:8]` when its acknowledge pulse ends. The second data byte is written to `cfg_word[7:0]` when its acknowledge pulse ends. The other half keeps its value, and the two halves never change in the same cycle.
- R8: A repeated START at any point in a transfer restarts address reception. A full write after it loads the word normally.
- R9: A STOP after only the first data byte leaves the new upper half and the old lower half in place, and releases the line.
- R10: A third data byte in the same transfer gets no acknowledge and does not alter `cfg_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_pick | input | 1 | Selects the address LSB (LSB = inverse of this pin) |
| sda_pull_low | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_word | output | 16 | Configuration word loaded by the write transfers |

## Verification
The bench builds the block with its default parameters: the upper address bits 001011 and two synchroniser stages. It runs the bus at 40 system clocks per bit, which leaves ten clocks per quarter bit for the synchroniser and edge-detect latency. With these values, both settings of `addr_pick` can be tested against the two fixed addresses. This covers a foreign address, a read bit, a transfer stopped after one byte, a repeated START in the middle of a write, and a surplus third byte. Every acknowledge slot and every register update is checked.

// File: rtl/i2c_word_rx_pkg.sv
package i2c_word_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_HI_BYTE,
    ST_HI_ACK,
    ST_LO_BYTE,
    ST_LO_ACK,
    ST_IGNORE
  } rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] now,
  output logic [LINES-1:0] last
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[DEPTH-2:0], raw[g]};
    end
    assign now[g]  = chain_q[DEPTH-2];
    assign last[g] = chain_q[DEPTH-1];
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl_now,
  input  logic scl_last,
  input  logic sda_now,
  input  logic sda_last,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_steady_high;
  assign scl_steady_high = scl_now && scl_last;
  assign scl_rise  = scl_now && !scl_last;
  assign scl_fall  = !scl_now && scl_last;
  assign start_det = scl_steady_high && sda_last && !sda_now;
  assign stop_det  = scl_steady_high && !sda_last && sda_now;
endmodule

// File: rtl/i2c_word_fsm.sv
module i2c_word_fsm
  import i2c_word_rx_pkg::*;
#(
  parameter logic [5:0] ADDR_UPPER = 6'b001011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_now,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_pick,
  output logic              pull_low,
  output logic [WORD_W-1:0] word
);
  localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

  rx_state_e             state_q, state_d;
  logic [BIT_CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0]     shift_q, shift_d;
  logic                  pull_q, pull_d;
  logic [BYTE_W-1:0]     hi_q, hi_d, lo_q, lo_d;
  logic [BYTE_W-1:0]     own_addr;
  logic                  receiving;

  assign own_addr  = {ADDR_UPPER, ~addr_pick, 1'b0};
  assign receiving = (state_q == ST_ADDR) || (state_q == ST_HI_BYTE) ||
                     (state_q == ST_LO_BYTE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    pull_d  = pull_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (receiving) begin
      if (scl_rise && cnt_q != FULL) begin
        shift_d = {shift_q[BYTE_W-2:0], sda_now};
        cnt_d   = cnt_q + 1'b1;
      end else if (scl_fall && cnt_q == FULL) begin
        cnt_d = '0;
        unique case (state_q)
          ST_ADDR: begin
            if (shift_q == own_addr) begin
              pull_d  = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IGNORE;
            end
          end
          ST_HI_BYTE: begin
            pull_d  = 1'b1;
            state_d = ST_HI_ACK;
          end
          default: begin
            pull_d  = 1'b1;
            state_d = ST_LO_ACK;
          end
        endcase
      end
    end else if (scl_fall) begin
      unique case (state_q)
        ST_ADDR_ACK: begin
          pull_d  = 1'b0;
          state_d = ST_HI_BYTE;
        end
        ST_HI_ACK: begin
          pull_d  = 1'b0;
          hi_d    = shift_q;
          state_d = ST_LO_BYTE;
        end
        ST_LO_ACK: begin
          pull_d  = 1'b0;
          lo_d    = shift_q;
          state_d = ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      pull_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      pull_q  <= pull_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign pull_low = pull_q;
  assign word     = {hi_q, lo_q};
endmodule

// File: rtl/i2c_word_rx.sv
module i2c_word_rx
  import i2c_word_rx_pkg::*;
#(
  parameter logic [5:0] ADDR_UPPER  = 6'b001011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_pick,
  output logic              sda_pull_low,
  output logic [WORD_W-1:0] cfg_word
);
  logic [1:0] line_now, line_last;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({scl_in, sda_in}),
    .now  (line_now),
    .last (line_last)
  );

  assign scl_s = line_now[1];
  assign sda_s = line_now[0];

  i2c_bus_events u_events (
    .scl_now  (line_now[1]),
    .scl_last (line_last[1]),
    .sda_now  (line_now[0]),
    .sda_last (line_last[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_word_fsm #(.ADDR_UPPER(ADDR_UPPER)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_now  (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .addr_pick(addr_pick),
    .pull_low (sda_pull_low),
    .word     (cfg_word)
  );
endmodule

// File: rtl/i2c_word_rx_chk.sv
module i2c_word_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_q,
  input logic        stop_q,
  input logic        pull,
  input logic [15:0] word
);
  AST_PULL_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !scl_q); // R6
  AST_PULL_FALLS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull) |-> !scl_q); // R6
  AST_PULL_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(pull)); // R6
  AST_WORD_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> !scl_q); // R7
  AST_ONE_HALF_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(word[15:8]) && !$stable(word[7:0]))); // R7
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !pull); // R2
endmodule

bind i2c_word_rx i2c_word_rx_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .scl_q (scl_s),
  .stop_q(stop_det),
  .pull  (sda_pull_low),
  .word  (cfg_word)
);

// File: tb/tb_i2c_word_rx.sv
module tb_i2c_word_rx;
  localparam int QTR = 10;

  typedef struct {
    string       tag;
    logic [15:0] val;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        scl_m, sda_m, addr_pick;
  logic        sda_pull_low;
  logic [15:0] cfg_word;
  logic        sda_line;

  item_t exp_q[$];
  item_t got_q[$];
  int    n_vec;
  int    n_bad;
  bit    done;

  assign sda_line = sda_m & ~sda_pull_low;

  i2c_word_rx dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_m),
    .sda_in      (sda_line),
    .addr_pick   (addr_pick),
    .sda_pull_low(sda_pull_low),
    .cfg_word    (cfg_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wait_q(input int n);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic push(input string tag, input logic [15:0] expv, input logic [15:0] gotv);
    item_t e, g;
    e.tag = tag; e.val = expv;
    g.tag = tag; g.val = gotv;
    exp_q.push_back(e);
    got_q.push_back(g);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop(input string tag);
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b1; wait_q(2);
    push({tag, " line released after stop"}, 16'd0, {15'd0, sda_pull_low});
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack_exp, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(1);
      scl_m = 1'b1; wait_q(2);
      scl_m = 1'b0; wait_q(1);
    end
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    push({tag, " ack slot"}, {15'd0, ack_exp}, {15'd0, sda_pull_low});
    wait_q(1);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic check_word(input logic [15:0] expv, input string tag);
    push({tag, " cfg_word"}, expv, cfg_word);
  endtask

  // Monitor: pops expected and observed items and compares them.
  initial begin
    n_vec = 0;
    n_bad = 0;
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && got_q.size() > 0) begin
        item_t e, g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        n_vec++;
        if (e.val !== g.val) begin
          n_bad++;
          $display("FAIL %s: got %h expected %h", e.tag, g.val, e.val);
        end
      end
    end
  end

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_pick = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_q(1);
    // R1: reset state
    push("R1 reset cfg_word", 16'h0000, cfg_word);
    push("R1 reset line", 16'h0000, {15'd0, sda_pull_low});

    // R3 R6 R7 R2: select low, address 0010111 + write
    bus_start();
    send_byte(8'h2E, 1'b1, "R3 addr sel0");
    send_byte(8'hA5, 1'b1, "R6 hi byte");
    check_word(16'hA500, "R7 hi half");
    send_byte(8'h3C, 1'b1, "R6 lo byte");
    check_word(16'hA53C, "R7 lo half");
    bus_stop("R2");

    // R3: select high, address 0010110 + write
    addr_pick = 1'b1;
    bus_start();
    send_byte(8'h2C, 1'b1, "R3 addr sel1");
    send_byte(8'h12, 1'b1, "R3 hi byte");
    send_byte(8'h34, 1'b1, "R3 lo byte");
    check_word(16'h1234, "R3 word");
    bus_stop("R2");

    // R4: foreign address (sel0 address while sel high)
    bus_start();
    send_byte(8'h2E, 1'b0, "R4 foreign addr");
    send_byte(8'hFF, 1'b0, "R4 data after foreign");
    check_word(16'h1234, "R4 unchanged");
    bus_stop("R4");

    // R5: read bit set
    bus_start();
    send_byte(8'h2D, 1'b0, "R5 read addr");
    send_byte(8'h00, 1'b0, "R5 data after read");
    check_word(16'h1234, "R5 unchanged");
    bus_stop("R5");

    // R9: stop after first data byte
    bus_start();
    send_byte(8'h2C, 1'b1, "R9 addr");
    send_byte(8'h77, 1'b1, "R9 hi byte");
    bus_stop("R9");
    check_word(16'h7734, "R9 partial word");

    // R8 R10: repeated start mid-transfer, then a surplus byte
    bus_start();
    send_byte(8'h2C, 1'b1, "R8 first addr");
    send_byte(8'h55, 1'b1, "R8 first hi");
    check_word(16'h5534, "R8 first hi half");
    bus_start();
    send_byte(8'h2C, 1'b1, "R8 addr after restart");
    send_byte(8'h66, 1'b1, "R8 hi after restart");
    check_word(16'h6634, "R8 hi half after restart");
    send_byte(8'h99, 1'b1, "R8 lo after restart");
    check_word(16'h6699, "R8 word after restart");
    send_byte(8'hEE, 1'b0, "R10 third byte");
    check_word(16'h6699, "R10 unchanged");
    bus_stop("R10");

    wait_q(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule